// File: doc/BRIEF.md
# Narrow-Memory Read Bridge with Rotation

This block connects a 32-bit CPU read port to two memories. One is a fast on-chip RAM with a 32-bit data path. The other is a slower external RAM with a 16-bit data path. The top byte of the address selects the memory. Every read returns a 32-bit result, and each memory's wait states are set by a parameter.

On the fast RAM the bridge reads the whole aligned word once. On the 16-bit RAM a byte or halfword read fetches only the one halfword that holds the requested data, so the upper and lower halfword of a word cost the same number of cycles. A word read fetches the low halfword and then the high halfword. The bridge builds the 32-bit word from the fetched data. It then applies the load rules of a common RISC core: a misaligned word is returned rotated, a byte is zero-extended, and a halfword at an odd address is returned rotated by one byte.

A read is started with a one-cycle `req` pulse, and only one read is handled at a time. `ready` pulses for one cycle and `rdata` is valid in that cycle. An address outside both regions returns zero without touching either memory.

Top module: `narrow_read_bridge`

## Requirements
- R1: Region decode uses `addr[31:24]`. The value 0x02 selects the 16-bit RAM, 0x03 selects the 32-bit RAM, and any other value is unmapped. At most one memory enable is high in any cycle.
- R2: The `size` encoding is 0 = byte, 1 = halfword, 2 or 3 = word. A `req` is accepted on a rising edge only when the bridge is idle. Latency N means `ready` is high in the cycle that begins N−1 rising edges after the accepting edge. `ready` is high for exactly one cycle per accepted read.
- R3: Every read from the 32-bit RAM has latency FAST_WS+2, for every size and every value of `addr[1:0]`.
- R4: A byte or halfword read from the 16-bit RAM makes one fetch of the halfword with index `{addr[SLOW_AW:2], addr[1]}`. That fetch holds `sr_en` high for SLOW_WS+1 cycles, and the read has latency SLOW_WS+2 for every value of `addr[1:0]`.
- R5: A word read from the 16-bit RAM makes two fetches. The first is at halfword index bit 0 = 0 and the second at bit 0 = 1, with SLOW_WS+1 enable cycles each. The read has latency 2·SLOW_WS+3.
- R6: A word read returns the aligned word rotated right by 8·`addr[1:0]` bits.
- R7: A halfword read takes the aligned halfword selected by `addr[1]` and zero-extends it to 32 bits. If `addr[0]` is 1, the 32-bit value is rotated right by 8 bits. No error is raised.
- R8: A byte read returns the byte at `addr[1:0]` of the aligned word, zero-extended.
- R9: An unmapped read returns zero with latency 1 and raises no memory enable.
- R10: `rdata` is zero whenever `ready` is low.
- R11: A `req` that arrives while a read is in progress is ignored. It starts no read and causes no extra `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-cycle read request |
| addr | input | 32 | Byte address |
| size | input | 2 | Access size (0 byte, 1 half, 2/3 word) |
| ready | output | 1 | One-cycle pulse, read data valid |
| rdata | output | 32 | Rotated / extended read result |
| fr_en | output | 1 | 32-bit RAM read enable |
| fr_addr | output | FAST_AW | 32-bit RAM word index |
| fr_rdata | input | 32 | 32-bit RAM read data (combinational) |
| sr_en | output | 1 | 16-bit RAM read enable |
| sr_addr | output | SLOW_AW | 16-bit RAM halfword index |
| sr_rdata | input | 16 | 16-bit RAM read data (combinational) |

## Verification
The bench builds the bridge with FAST_WS=1 and SLOW_WS=3 and keeps the default address widths. Both waits are nonzero and unequal, so each latency formula (unmapped, fast, slow sub-word, slow word) produces a different cycle count. A wait counter that fails to restart between the two halfword fetches of a word read also changes the measured latency. With these values the slow RAM is visibly slower than the fast RAM for every access shape. The bench also counts enable cycles and records fetch addresses at the memory ports. These counts show how many halfwords were fetched and in what order.

// File: rtl/nrb_pkg.sv
// Shared types and helpers for the narrow-memory read bridge.
// Assumes a 32-bit little-endian CPU data path.
package nrb_pkg;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_FAST = 2'd1,
        RG_SLOW = 2'd2
    } region_e;

    localparam logic [7:0] SLOW_REGION_TAG = 8'h02;
    localparam logic [7:0] FAST_REGION_TAG = 8'h03;

    // Rotate a word right by a whole number of bytes.
    function automatic logic [31:0] ror_bytes(input logic [31:0] w, input logic [1:0] nb);
        logic [31:0] r;
        case (nb)
            2'd0:    r = w;
            2'd1:    r = {w[7:0],  w[31:8]};
            2'd2:    r = {w[15:0], w[31:16]};
            default: r = {w[23:0], w[31:24]};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nrb_region_decode.sv
// Region decoder: maps the top address byte to a target memory.
// Assumes the region tag occupies the whole top byte; everything else is unmapped.
module nrb_region_decode
    import nrb_pkg::*;
(
    input  logic [7:0] addr_tag,
    output region_e    region
);

    // Pure tag comparison; no state.
    always_comb begin
        if (addr_tag == SLOW_REGION_TAG)      region = RG_SLOW;
        else if (addr_tag == FAST_REGION_TAG) region = RG_FAST;
        else                                  region = RG_NONE;
    end

endmodule

// File: rtl/nrb_fetch_ctrl.sv
// Fetch sequencer: accepts one request at a time, runs the wait-state counter,
// issues one fast word fetch or one/two slow halfword fetches, and collects the
// fetched data into two halfword lanes.
// Assumes both memories return read data combinationally while enabled.
module nrb_fetch_ctrl
    import nrb_pkg::*;
#(
    parameter int FAST_AW = 9,
    parameter int SLOW_AW = 10,
    parameter int FAST_WS = 0,
    parameter int SLOW_WS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  region_e            req_region,
    input  logic [31:0]        req_addr,
    input  logic [1:0]         req_size,
    output logic               fr_en,
    output logic [FAST_AW-1:0] fr_addr,
    input  logic [31:0]        fr_rdata,
    output logic               sr_en,
    output logic [SLOW_AW-1:0] sr_addr,
    input  logic [15:0]        sr_rdata,
    output logic               resp_valid,
    output logic [31:0]        resp_word,
    output logic [1:0]         resp_off,
    output logic [1:0]         resp_size
);

    localparam int MAX_WS = (FAST_WS > SLOW_WS) ? FAST_WS : SLOW_WS;
    localparam int CNT_W  = $clog2(MAX_WS + 2);
    localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_WS);
    localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_WS);
    localparam int LANES  = 2;

    typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_RESP} state_e;

    state_e               state;
    region_e              lat_region;
    logic [1:0]           lat_off;
    logic [1:0]           lat_size;
    logic [FAST_AW-1:0]   lat_fidx;
    logic [SLOW_AW-2:0]   lat_sidx;
    logic [CNT_W-1:0]     cnt;
    logic                 phase;
    logic [LANES-1:0][15:0] lane_q;

    logic                 accept;
    logic [CNT_W-1:0]     ws_lim;
    logic                 last_wait;
    logic                 two_phase;
    logic                 lane_sel;
    logic                 capture;

    // Control decodes derived from the latched request.
    always_comb begin
        accept    = (state == ST_IDLE) && req;
        ws_lim    = (lat_region == RG_FAST) ? FAST_LIM : SLOW_LIM;
        last_wait = (cnt == ws_lim);
        two_phase = (lat_region == RG_SLOW) && lat_size[1];
        lane_sel  = lat_size[1] ? phase : lat_off[1];
        capture   = (state == ST_ACCESS) && last_wait;
    end

    // Sequencer state, wait counter and request latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            lat_region <= RG_NONE;
            lat_off    <= '0;
            lat_size   <= '0;
            lat_fidx   <= '0;
            lat_sidx   <= '0;
            cnt        <= '0;
            phase      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        lat_region <= req_region;
                        lat_off    <= req_addr[1:0];
                        lat_size   <= req_size;
                        lat_fidx   <= req_addr[FAST_AW+1:2];
                        lat_sidx   <= req_addr[SLOW_AW:2];
                        cnt        <= '0;
                        phase      <= 1'b0;
                        state      <= (req_region == RG_NONE) ? ST_RESP : ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (last_wait) begin
                        if (two_phase && !phase) begin
                            phase <= 1'b1;
                            cnt   <= '0;
                        end else begin
                            state <= ST_RESP;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // One data-collection register per halfword lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Clear on acceptance, then load from whichever memory serves this lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (accept) begin
                lane_q[g] <= '0;
            end else if (capture) begin
                if (lat_region == RG_FAST)
                    lane_q[g] <= fr_rdata[16*g +: 16];
                else if (lane_sel == 1'(g))
                    lane_q[g] <= sr_rdata;
            end
        end
    end

    // Memory-side drive and response outputs.
    always_comb begin
        fr_en      = (state == ST_ACCESS) && (lat_region == RG_FAST);
        fr_addr    = lat_fidx;
        sr_en      = (state == ST_ACCESS) && (lat_region == RG_SLOW);
        sr_addr    = {lat_sidx, lane_sel};
        resp_valid = (state == ST_RESP);
        resp_word  = {lane_q[1], lane_q[0]};
        resp_off   = lat_off;
        resp_size  = lat_size;
    end

endmodule

// File: rtl/nrb_align.sv
// Result aligner: applies byte/halfword extraction and misaligned rotation to
// the assembled aligned word. Purely combinational.
// Assumes size 2 and 3 both mean a full word.
module nrb_align
    import nrb_pkg::*;
(
    input  logic [31:0] word,
    input  logic [1:0]  off,
    input  logic [1:0]  size,
    output logic [31:0] data
);

    logic [31:0] shifted;
    logic [15:0] half;

    // Select the size-specific view of the aligned word.
    always_comb begin
        shifted = ror_bytes(word, off);
        half    = off[1] ? word[31:16] : word[15:0];
        if (size[1])
            data = shifted;
        else if (size[0])
            data = ror_bytes({16'h0000, half}, {1'b0, off[0]});
        else
            data = {24'h000000, shifted[7:0]};
    end

endmodule

// File: rtl/narrow_read_bridge.sv
// Narrow-memory read bridge: decodes the region, sequences fetches from a 32-bit
// or 16-bit RAM with parameter-set wait states, and returns a rotated result.
// Assumes one outstanding request and combinational memory read data.
module narrow_read_bridge
    import nrb_pkg::*;
#(
    parameter int FAST_AW = 9,
    parameter int SLOW_AW = 10,
    parameter int FAST_WS = 0,
    parameter int SLOW_WS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [31:0]        addr,
    input  logic [1:0]         size,
    output logic               ready,
    output logic [31:0]        rdata,
    output logic               fr_en,
    output logic [FAST_AW-1:0] fr_addr,
    input  logic [31:0]        fr_rdata,
    output logic               sr_en,
    output logic [SLOW_AW-1:0] sr_addr,
    input  logic [15:0]        sr_rdata
);

    region_e     region;
    logic        resp_valid;
    logic [31:0] resp_word;
    logic [1:0]  resp_off;
    logic [1:0]  resp_size;
    logic [31:0] aligned;

    nrb_region_decode u_dec (
        .addr_tag (addr[31:24]),
        .region   (region)
    );

    nrb_fetch_ctrl #(
        .FAST_AW (FAST_AW),
        .SLOW_AW (SLOW_AW),
        .FAST_WS (FAST_WS),
        .SLOW_WS (SLOW_WS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_region (region),
        .req_addr   (addr),
        .req_size   (size),
        .fr_en      (fr_en),
        .fr_addr    (fr_addr),
        .fr_rdata   (fr_rdata),
        .sr_en      (sr_en),
        .sr_addr    (sr_addr),
        .sr_rdata   (sr_rdata),
        .resp_valid (resp_valid),
        .resp_word  (resp_word),
        .resp_off   (resp_off),
        .resp_size  (resp_size)
    );

    nrb_align u_align (
        .word (resp_word),
        .off  (resp_off),
        .size (resp_size),
        .data (aligned)
    );

    // Gate the result so the bus reads zero outside the response cycle.
    always_comb begin
        ready = resp_valid;
        rdata = resp_valid ? aligned : 32'h0;
    end

endmodule

// File: rtl/nrb_checker.sv
// Protocol checker for the read bridge, built only from its ports.
// Tracks acceptance itself and measures each read's latency with a counter.
module nrb_checker #(
    parameter int FAST_WS = 0,
    parameter int SLOW_WS = 2,
    parameter int SLOW_AW = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req,
    input logic [31:0]        addr,
    input logic [1:0]         size,
    input logic               ready,
    input logic [31:0]        rdata,
    input logic               fr_en,
    input logic               sr_en,
    input logic [SLOW_AW-1:0] sr_addr
);

    logic        busy;
    logic [7:0]  tag_q;
    logic [1:0]  size_q;
    logic        abit1_q;
    logic [15:0] age;
    logic [15:0] want;
    logic        accept;
    logic        unmapped_req;

    // Acceptance as seen from the ports.
    always_comb begin
        accept       = req && !busy;
        unmapped_req = accept && (addr[31:24] != 8'h02) && (addr[31:24] != 8'h03);
        if (tag_q == 8'h03)      want = 16'(FAST_WS + 2);
        else if (tag_q != 8'h02) want = 16'd1;
        else if (size_q[1])      want = 16'(2 * SLOW_WS + 3);
        else                     want = 16'(SLOW_WS + 2);
    end

    // Busy flag, request latch and cycle counter since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            tag_q   <= '0;
            size_q  <= '0;
            abit1_q <= 1'b0;
            age     <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            tag_q   <= addr[31:24];
            size_q  <= size;
            abit1_q <= addr[1];
            age     <= 16'd1;
        end else if (busy) begin
            if (ready) busy <= 1'b0;
            age <= age + 16'd1;
        end
    end

    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    p_ready_only_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> busy);

    p_one_memory_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(fr_en && sr_en));

    p_zero_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (rdata == 32'h0));

    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_req |=> (ready && rdata == 32'h0 && !fr_en && !sr_en));

    // Covers the latency rules of R3, R4 and R5 together.
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (age == want));

    p_first_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_en) |-> (sr_addr[0] == (size_q[1] ? 1'b0 : abit1_q)));

    p_second_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_en && $past(sr_en) && (sr_addr[0] != $past(sr_addr[0]))) |-> (size_q[1] && sr_addr[0]));

endmodule

bind narrow_read_bridge nrb_checker #(
    .FAST_WS (FAST_WS),
    .SLOW_WS (SLOW_WS),
    .SLOW_AW (SLOW_AW)
) u_nrb_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .addr    (addr),
    .size    (size),
    .ready   (ready),
    .rdata   (rdata),
    .fr_en   (fr_en),
    .sr_en   (sr_en),
    .sr_addr (sr_addr)
);

// File: tb/narrow_read_bridge_test.sv
// Directed bench: one task per scenario, each checking its own results.
module narrow_read_bridge_test;

    localparam int CLK_PERIOD = 10;
    localparam int FAST_AW = 9;
    localparam int SLOW_AW = 10;
    localparam int FAST_WS = 1;
    localparam int SLOW_WS = 3;
    localparam int WATCHDOG = 20000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req = 1'b0;
    logic [31:0]        addr = '0;
    logic [1:0]         size = '0;
    logic               ready;
    logic [31:0]        rdata;
    logic               fr_en;
    logic [FAST_AW-1:0] fr_addr;
    logic [31:0]        fr_rdata;
    logic               sr_en;
    logic [SLOW_AW-1:0] sr_addr;
    logic [15:0]        sr_rdata;

    logic [31:0] fmem [2**FAST_AW];
    logic [15:0] smem [2**SLOW_AW];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int sr_cycles = 0;
    int fr_cycles = 0;
    logic [SLOW_AW-1:0] sr_first = '0;
    logic [SLOW_AW-1:0] sr_last = '0;
    logic sr_en_d = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign fr_rdata = fmem[fr_addr];
    assign sr_rdata = smem[sr_addr];

    narrow_read_bridge #(
        .FAST_AW (FAST_AW),
        .SLOW_AW (SLOW_AW),
        .FAST_WS (FAST_WS),
        .SLOW_WS (SLOW_WS)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .addr     (addr),
        .size     (size),
        .ready    (ready),
        .rdata    (rdata),
        .fr_en    (fr_en),
        .fr_addr  (fr_addr),
        .fr_rdata (fr_rdata),
        .sr_en    (sr_en),
        .sr_addr  (sr_addr),
        .sr_rdata (sr_rdata)
    );

    // Memory-port monitor: enable-cycle totals and fetch addresses.
    always @(posedge clk) begin
        if (sr_en) begin
            sr_cycles = sr_cycles + 1;
            if (!sr_en_d) sr_first = sr_addr;
            sr_last = sr_addr;
        end
        if (fr_en) fr_cycles = fr_cycles + 1;
        sr_en_d = sr_en;
    end

    task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ror8(logic [31:0] w, int nb);
        logic [31:0] r = w;
        for (int i = 0; i < nb; i++) r = {r[7:0], r[31:8]};
        return r;
    endfunction

    // Expected result from the load rules, given the aligned word.
    function automatic logic [31:0] model(logic [31:0] w, logic [1:0] off, logic [1:0] sz);
        logic [15:0] h;
        if (sz[1]) return ror8(w, int'(off));
        if (sz[0]) begin
            h = off[1] ? w[31:16] : w[15:0];
            return ror8({16'h0, h}, off[0] ? 1 : 0);
        end
        return {24'h0, ror8(w, int'(off))[7:0]};
    endfunction

    function automatic logic [31:0] mem_word(logic [31:0] a);
        if (a[31:24] == 8'h03) return fmem[a[FAST_AW+1:2]];
        if (a[31:24] == 8'h02) return {smem[{a[SLOW_AW:2], 1'b1}], smem[{a[SLOW_AW:2], 1'b0}]};
        return 32'h0;
    endfunction

    function automatic int exp_lat(logic [31:0] a, logic [1:0] sz);
        if (a[31:24] == 8'h03) return FAST_WS + 2;
        if (a[31:24] == 8'h02) return sz[1] ? 2 * SLOW_WS + 3 : SLOW_WS + 2;
        return 1;
    endfunction

    // Issue one read, measure its latency, then confirm ready dropped.
    task automatic do_read(input logic [31:0] a, input logic [1:0] sz,
                           output logic [31:0] data, output int lat);
        @(negedge clk);
        req = 1'b1; addr = a; size = sz;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!ready && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        data = rdata;
        @(negedge clk);
        check("R2", "ready single pulse", {31'h0, ready}, 32'h0);
        check("R10", "rdata zero after pulse", rdata, 32'h0);
    endtask

    task automatic t_reset;
        check("R2", "ready low after reset", {31'h0, ready}, 32'h0);
        check("R10", "rdata zero after reset", rdata, 32'h0);
        check("R1", "no enables after reset", {30'h0, fr_en, sr_en}, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d; int lat; int f0; int s0;
        logic [31:0] al [3] = '{32'h0400_0010, 32'h0000_0000, 32'hFF03_0002};
        foreach (al[i]) begin
            f0 = fr_cycles; s0 = sr_cycles;
            do_read(al[i], 2'd2, d, lat);
            check("R9", "unmapped data", d, 32'h0);
            check("R9", "unmapped latency", lat, 1);
            check("R9", "unmapped enables", (fr_cycles - f0) + (sr_cycles - s0), 0);
        end
    endtask

    task automatic t_fast;
        logic [31:0] d; int lat; int s0;
        for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 4; off++) begin
                logic [31:0] a = 32'h0300_0040 + 32'(sz * 16) + 32'(off);
                s0 = sr_cycles;
                do_read(a, 2'(sz), d, lat);
                check(sz >= 2 ? "R6" : (sz == 1 ? "R7" : "R8"), "fast data",
                      d, model(mem_word(a), a[1:0], 2'(sz)));
                check("R3", "fast latency", lat, FAST_WS + 2);
                check("R1", "fast no slow enable", sr_cycles - s0, 0);
            end
        end
    endtask

    task automatic t_slow_sub;
        logic [31:0] d; int lat; int s0;
        for (int sz = 0; sz < 2; sz++) begin
            for (int off = 0; off < 4; off++) begin
                logic [31:0] a = 32'h0200_0100 + 32'(sz * 8) + 32'(off);
                s0 = sr_cycles;
                do_read(a, 2'(sz), d, lat);
                check(sz == 1 ? "R7" : "R8", "slow sub-word data",
                      d, model(mem_word(a), a[1:0], 2'(sz)));
                check("R4", "slow sub-word latency", lat, SLOW_WS + 2);
                check("R4", "one fetch only", sr_cycles - s0, SLOW_WS + 1);
                check("R4", "fetched halfword index", 32'(sr_first),
                      32'({a[SLOW_AW:2], a[1]}));
            end
        end
    endtask

    task automatic t_slow_word;
        logic [31:0] d; int lat; int s0;
        for (int off = 0; off < 4; off++) begin
            logic [31:0] a = 32'h0200_0230 + 32'(off);
            s0 = sr_cycles;
            do_read(a, 2'd2, d, lat);
            check("R6", "slow word rotated", d, model(mem_word(a), a[1:0], 2'd2));
            check("R5", "slow word latency", lat, 2 * SLOW_WS + 3);
            check("R5", "two fetches", sr_cycles - s0, 2 * (SLOW_WS + 1));
            check("R5", "low half first", {31'h0, sr_first[0]}, 32'h0);
            check("R5", "high half last", {31'h0, sr_last[0]}, 32'h1);
        end
        check("R5", "slower than fast", (2 * SLOW_WS + 3) > exp_lat(32'h0300_0000, 2'd2) ? 1 : 0, 1);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] a = 32'h0200_0344;
        int pulses = 0; int s0 = sr_cycles; int f0 = fr_cycles;
        logic [31:0] d = '0;
        @(negedge clk);
        req = 1'b1; addr = a; size = 2'd2;
        @(negedge clk);
        req = 1'b1; addr = 32'h0300_0008; size = 2'd0;
        @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (ready) begin pulses++; d = rdata; end
            @(negedge clk);
        end
        check("R11", "ready pulses", pulses, 1);
        check("R11", "first read data kept", d, mem_word(a));
        check("R11", "no fast fetch from ignored req", fr_cycles - f0, 0);
        check("R11", "slow fetch count", sr_cycles - s0, 2 * (SLOW_WS + 1));
    endtask

    initial begin
        for (int i = 0; i < 2**FAST_AW; i++) fmem[i] = 32'h1357_9BDF ^ (32'(i) * 32'h0103_0507);
        for (int i = 0; i < 2**SLOW_AW; i++) smem[i] = 16'hA5C3 ^ (16'(i) * 16'h0137);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unmapped();
        t_fast();
        t_slow_sub();
        t_slow_word();
        t_busy_ignore();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule